// File: doc/BRIEF.md
# External Memory Space Select Unit

This unit sits between a small 8-bit processor core and its external bus. Program space and data space share the same 16-bit external address range of up to 64 KB each. The active-low data-space strobe is the only signal that tells them apart. For each external machine cycle, the core requests a cycle and gives its kind and its length. The unit then produces the address strobe and the data strobe for that cycle. It also computes the data-space strobe once, at the start of the cycle, and holds it until the cycle ends.

The data-space strobe goes low for explicit external data loads. It also goes low for stack reads and stack writes, but only when the stack is configured to live in external memory. It stays high for instruction fetches and for reads of data out of program memory.

Two write-only configuration bytes select the role of the shared port pin:
- a plain output carrying a stored data bit,
- the data-space strobe,
- or a line handed to the handshake logic.

The same bytes also select where the stack lives.

Top module: `memsel_top`

## Requirements
- R1: After reset (rstN low, asynchronous), asN, dsN and dmN are high, busy and p34Hs are low, and p34Out follows portOutBit, because both configuration bytes reset to zero.
- R2: A write with cfgWrEn high takes effect at the clock edge.
  - Address F7h stores the pin mode from cfgData[4:3]: 00 plain output, 01 or 10 strobe, 11 handshake.
  - Address F8h stores the stack location from cfgData[2]: 0 external, 1 internal.
  - Writes to any other address change nothing.
- R3: A request (cycReq high while busy is low) starts a cycle only when cycType is one of 1 fetch, 2 data load, 3 stack read, 4 stack write, 5 program data read. Codes 0, 6 and 7 start nothing, and requests made while busy are ignored.
- R4: A started cycle keeps busy high for exactly L clocks. L is cycLen clamped to the range 6 to 12, sampled at the start edge.
- R5: asN is low during the first clock of each cycle only.
- R6: dsN is low from the second clock of a cycle through clock L-1, and high in the first and last clocks.
- R7: For a data load, dmN is low for the whole cycle when the pin mode is 01 or 10, and high in pin modes 00 and 11. dmN is high whenever no cycle runs.
- R8: dmN stays high for fetch and program-data-read cycles.
- R9: Stack reads and stack writes drive dmN low only when the stack location is external and the pin mode is 01 or 10.
- R10: In pin mode 00, p34Out equals portOutBit. In modes 01 and 10, p34Out equals dmN. In mode 11, p34Hs is high, p34Out is high and dmN stays high. p34Hs is low in the other modes.
- R11: dmN is fixed at the start of a cycle. A configuration write during the cycle does not change it before the cycle ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write enable |
| cfgAddr | input | 8 | Configuration register address |
| cfgData | input | 8 | Configuration write data |
| portOutBit | input | 1 | Stored port output data bit for plain-output mode |
| cycReq | input | 1 | Request to start an external machine cycle |
| cycType | input | 3 | Kind of cycle requested |
| cycLen | input | 4 | Requested cycle length in clocks (clamped 6..12) |
| busy | output | 1 | A machine cycle is in progress |
| asN | output | 1 | Address strobe, active low |
| dsN | output | 1 | Data strobe, active low |
| dmN | output | 1 | Data-space select strobe, active low |
| p34Out | output | 1 | Value driven onto the shared port pin |
| p34Hs | output | 1 | Shared pin handed to the handshake logic |

## Verification
A request accepted at a rising edge shows its first beat in the clock period that follows that edge:
- asN is low, busy is high and dmN holds its final value.
- dsN falls one clock later and rises one clock before busy drops, L clocks after the start edge.

A configuration write is visible on p34Out and p34Hs right after its edge. It reaches dmN only at the next cycle start.

The driver queues one expected beat per clock of each cycle. The monitor compares one beat at each falling edge while busy is high, so every value is read half a period after the edge that set it. An empty queue at the end of each cycle confirms its length.

// File: rtl/memsel_pkg.sv
package memsel_pkg;

  typedef enum logic [2:0] {
    CYC_IDLE   = 3'd0,
    CYC_FETCH  = 3'd1,
    CYC_DLOAD  = 3'd2,
    CYC_STK_RD = 3'd3,
    CYC_STK_WR = 3'd4,
    CYC_PDATA  = 3'd5
  } cycKind_e;

  typedef enum logic [1:0] {
    PIN_GPO       = 2'd0,
    PIN_DM_A      = 2'd1,
    PIN_DM_B      = 2'd2,
    PIN_HANDSHAKE = 2'd3
  } pinMode_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic startStb;
    logic active;
    logic lastBeat;
  } seqStrobe_t;

endpackage

// File: rtl/memsel_seq.sv
module memsel_seq
  import memsel_pkg::*;
#(
  parameter int MIN_LEN = 6,
  parameter int MAX_LEN = 12,
  parameter int CNT_W   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cycReq,
  input  logic [2:0]       cycType,
  input  logic [CNT_W-1:0] cycLen,
  output seqStrobe_t       strb,
  output logic             asN,
  output logic             dsN
);

  localparam logic [CNT_W-1:0] LEN_LO = CNT_W'(MIN_LEN);
  localparam logic [CNT_W-1:0] LEN_HI = CNT_W'(MAX_LEN);
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

  logic             activeQ;
  logic [CNT_W-1:0] beatQ;
  logic [CNT_W-1:0] lenQ;
  logic [CNT_W-1:0] lenClamped;
  logic             typeValid;
  logic             startStb;
  logic             lastBeat;

  always_comb begin
    case (cycKind_e'(cycType))
      CYC_FETCH, CYC_DLOAD, CYC_STK_RD, CYC_STK_WR, CYC_PDATA: typeValid = 1'b1;
      default: typeValid = 1'b0;
    endcase
  end

  always_comb begin
    if (cycLen < LEN_LO)      lenClamped = LEN_LO;
    else if (cycLen > LEN_HI) lenClamped = LEN_HI;
    else                      lenClamped = cycLen;
  end

  assign startStb = cycReq && !activeQ && typeValid;
  assign lastBeat = activeQ && (beatQ == lenQ - ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      beatQ   <= '0;
      lenQ    <= LEN_LO;
    end else if (startStb) begin
      activeQ <= 1'b1;
      beatQ   <= '0;
      lenQ    <= lenClamped;
    end else if (lastBeat) begin
      activeQ <= 1'b0;
      beatQ   <= '0;
    end else if (activeQ) begin
      beatQ   <= beatQ + ONE;
    end
  end

  assign asN = !(activeQ && (beatQ == '0));
  assign dsN = !(activeQ && (beatQ != '0) && (beatQ < lenQ - ONE));

  assign strb.startStb = startStb;
  assign strb.active   = activeQ;
  assign strb.lastBeat = lastBeat;

  AST_AS_SINGLE_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    !asN |=> asN);  // R5

  AST_AS_DS_APART: assert property (@(posedge clk) disable iff (!rstN)
    !asN |-> dsN);  // R6

  AST_LEN_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    activeQ |-> (lenQ >= LEN_LO && lenQ <= LEN_HI));  // R4

  AST_NO_RESTART_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (activeQ && !lastBeat) |=> (activeQ && beatQ == $past(beatQ) + ONE));  // R3

endmodule

// File: rtl/memsel_dp.sv
module memsel_dp
  import memsel_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 8,
  parameter logic [7:0]  P3M_ADDR  = 8'hF7,
  parameter logic [7:0]  P01M_ADDR = 8'hF8,
  parameter int          MODE_LSB  = 3,
  parameter int          STACK_BIT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgData,
  input  logic [2:0]        cycType,
  input  logic              portOutBit,
  output logic              dmN,
  output logic              p34Out,
  output logic              p34Hs
);

  localparam logic [ADDR_W-1:0] MODE_REG  = ADDR_W'(P3M_ADDR);
  localparam logic [ADDR_W-1:0] STACK_REG = ADDR_W'(P01M_ADDR);

  logic [1:0] pinModeQ;
  logic       stackIntQ;
  logic       dmQ;
  pinMode_e   pinMode;
  logic       dmSelected;
  logic       dataSpace;
  logic       unusedCfgBits;

  assign unusedCfgBits = ^cfgData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinModeQ  <= 2'b00;
      stackIntQ <= 1'b0;
    end else if (cfgWrEn) begin
      if (cfgAddr == MODE_REG)  pinModeQ  <= cfgData[MODE_LSB+1:MODE_LSB];
      if (cfgAddr == STACK_REG) stackIntQ <= cfgData[STACK_BIT];
    end
  end

  assign pinMode    = pinMode_e'(pinModeQ);
  assign dmSelected = (pinMode == PIN_DM_A) || (pinMode == PIN_DM_B);

  always_comb begin
    case (cycKind_e'(cycType))
      CYC_DLOAD:              dataSpace = 1'b1;
      CYC_STK_RD, CYC_STK_WR: dataSpace = !stackIntQ;
      default:                dataSpace = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              dmQ <= 1'b0;
    else if (strb.startStb) dmQ <= dataSpace && dmSelected;
    else if (strb.lastBeat) dmQ <= 1'b0;
  end

  assign dmN = !dmQ;

  always_comb begin
    p34Hs = 1'b0;
    case (pinMode)
      PIN_GPO:            p34Out = portOutBit;
      PIN_DM_A, PIN_DM_B: p34Out = dmN;
      default: begin
        p34Out = 1'b1;
        p34Hs  = 1'b1;
      end
    endcase
  end

  AST_DM_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.active && $past(strb.active)) |-> $stable(dmN));  // R11

  AST_DM_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !strb.active |-> dmN);  // R7

endmodule

// File: rtl/memsel_top.sv
module memsel_top
  import memsel_pkg::*;
#(
  parameter int         MIN_LEN   = 6,
  parameter int         MAX_LEN   = 12,
  parameter int         CNT_W     = 4,
  parameter int         ADDR_W    = 8,
  parameter int         DATA_W    = 8,
  parameter logic [7:0] P3M_ADDR  = 8'hF7,
  parameter logic [7:0] P01M_ADDR = 8'hF8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgData,
  input  logic              portOutBit,
  input  logic              cycReq,
  input  logic [2:0]        cycType,
  input  logic [CNT_W-1:0]  cycLen,
  output logic              busy,
  output logic              asN,
  output logic              dsN,
  output logic              dmN,
  output logic              p34Out,
  output logic              p34Hs
);

  seqStrobe_t strb;

  memsel_seq #(
    .MIN_LEN(MIN_LEN),
    .MAX_LEN(MAX_LEN),
    .CNT_W  (CNT_W)
  ) uSeq (
    .clk    (clk),
    .rstN   (rstN),
    .cycReq (cycReq),
    .cycType(cycType),
    .cycLen (cycLen),
    .strb   (strb),
    .asN    (asN),
    .dsN    (dsN)
  );

  memsel_dp #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .P3M_ADDR (P3M_ADDR),
    .P01M_ADDR(P01M_ADDR)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cfgWrEn   (cfgWrEn),
    .cfgAddr   (cfgAddr),
    .cfgData   (cfgData),
    .cycType   (cycType),
    .portOutBit(portOutBit),
    .dmN       (dmN),
    .p34Out    (p34Out),
    .p34Hs     (p34Hs)
  );

  assign busy = strb.active;

endmodule

// File: tb/tb_memsel_top.sv
`timescale 1ns/1ps
module tb_memsel_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [7:0] cfgAddr = 8'h00;
  logic [7:0] cfgData = 8'h00;
  logic       portOutBit = 1'b1;
  logic       cycReq = 1'b0;
  logic [2:0] cycType = 3'd0;
  logic [3:0] cycLen = 4'd6;
  logic       busy, asN, dsN, dmN, p34Out, p34Hs;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  logic [1:0] benchMode = 2'b00;
  bit         benchStackExt = 1'b1;

  typedef struct {
    logic [4:0] vec;  // {asN, dsN, dmN, p34Out, p34Hs}
    string      tag;
  } beat_t;

  beat_t sbQ[$];
  beat_t curBeat;

  always #2 clk = ~clk;  // 250 MHz

  memsel_top dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .portOutBit(portOutBit), .cycReq(cycReq), .cycType(cycType), .cycLen(cycLen),
    .busy(busy), .asN(asN), .dsN(dsN), .dmN(dmN), .p34Out(p34Out), .p34Hs(p34Hs)
  );

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: one expected beat per busy clock
  always @(negedge clk) begin
    if (rstN && busy && !finished) begin
      if (sbQ.size() == 0) begin
        chk(1'b0, "R4 extra busy beat", {3'b0, asN, dsN, dmN, p34Out, p34Hs}, 8'h00);
      end else begin
        curBeat = sbQ.pop_front();
        chk({asN, dsN, dmN, p34Out, p34Hs} === curBeat.vec, curBeat.tag,
            {3'b0, asN, dsN, dmN, p34Out, p34Hs}, {3'b0, curBeat.vec});
      end
    end
  end

  function automatic int clampLen(input logic [3:0] l);
    if (l < 4'd6)  return 6;
    if (l > 4'd12) return 12;
    return int'(l);
  endfunction

  function automatic logic expDmLow(input logic [2:0] t);
    bit modeDm = (benchMode == 2'b01) || (benchMode == 2'b10);
    bit space  = (t == 3'd2) || (((t == 3'd3) || (t == 3'd4)) && benchStackExt);
    return modeDm && space;
  endfunction

  task automatic cfgWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // driver: queue expected beats, then run the cycle
  task automatic runCycle(input logic [2:0] t, input logic [3:0] lenIn,
                          input int pokeAt, input int midStackAt, input logic [7:0] midData,
                          input string tag);
    int   L    = clampLen(lenIn);
    logic dmE  = !expDmLow(t);
    logic p34E = (benchMode == 2'b00) ? portOutBit : (benchMode == 2'b11) ? 1'b1 : dmE;
    logic hsE  = (benchMode == 2'b11);
    for (int i = 0; i < L; i++) begin
      beat_t b;
      b.vec = {(i == 0) ? 1'b0 : 1'b1, (i >= 1 && i <= L - 2) ? 1'b0 : 1'b1, dmE, p34E, hsE};
      b.tag = tag;
      sbQ.push_back(b);
    end
    @(negedge clk);
    cycReq = 1'b1; cycType = t; cycLen = lenIn;
    for (int i = 1; i <= L; i++) begin
      @(negedge clk);
      if (i == 1) cycReq = 1'b0;
      if (i == pokeAt) begin cycReq = 1'b1; cycType = 3'd2; cycLen = 4'd12; end
      if (i == pokeAt + 1) cycReq = 1'b0;
      if (i == midStackAt) begin cfgWrEn = 1'b1; cfgAddr = 8'hF8; cfgData = midData; end
      if (i == midStackAt + 1) cfgWrEn = 1'b0;
    end
    @(negedge clk);
    chk(sbQ.size() == 0 && busy == 1'b0, {"R4 cycle length ", tag},
        {busy, 7'(sbQ.size())}, 8'h00);
    sbQ.delete();
  endtask

  task automatic tryIgnoredReq(input logic [2:0] t, input string tag);
    @(negedge clk);
    cycReq = 1'b1; cycType = t; cycLen = 4'd6;
    @(negedge clk);
    cycReq = 1'b0;
    chk(busy == 1'b0 && asN == 1'b1, tag, {6'b0, busy, asN}, 8'h01);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 8'h00, 8'h01);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk({asN, dsN, dmN, busy, p34Hs, p34Out} === 6'b111001, "R1 reset outputs",
        {2'b0, asN, dsN, dmN, busy, p34Hs, p34Out}, 8'h39);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk); portOutBit = 1'b0;
    #1;
    chk(p34Out === 1'b0 && p34Hs === 1'b0, "R1 R10 plain output follows data",
        {6'b0, p34Out, p34Hs}, 8'h00);
    portOutBit = 1'b1;

    // pin mode 00: strobe not on pin
    runCycle(3'd1, 4'd6, 0, 0, 8'h00, "R8 R5 R6 fetch mode 00");
    runCycle(3'd2, 4'd8, 0, 0, 8'h00, "R7 data load mode 00 dm high");

    // mode 01
    cfgWrite(8'hF7, 8'h08); benchMode = 2'b01;
    #1;
    chk(p34Out === 1'b1 && p34Hs === 1'b0, "R2 R10 mode 01 pin idle", {6'b0, p34Out, p34Hs}, 8'h02);
    runCycle(3'd2, 4'd0, 0, 0, 8'h00, "R7 R4 data load len clamp 6");
    runCycle(3'd1, 4'd15, 0, 0, 8'h00, "R8 R4 fetch len clamp 12");
    runCycle(3'd5, 4'd9, 0, 0, 8'h00, "R8 program data read");
    runCycle(3'd3, 4'd7, 0, 0, 8'h00, "R9 stack read external");
    runCycle(3'd4, 4'd6, 0, 0, 8'h00, "R9 stack write external");

    // stack internal
    cfgWrite(8'hF8, 8'h04); benchStackExt = 1'b0;
    runCycle(3'd3, 4'd6, 0, 0, 8'h00, "R9 R2 stack read internal");
    runCycle(3'd4, 4'd10, 0, 0, 8'h00, "R9 stack write internal");

    // mode 10
    cfgWrite(8'hF7, 8'h10); benchMode = 2'b10;
    runCycle(3'd2, 4'd12, 0, 0, 8'h00, "R7 R10 data load mode 10");

    // write to an unrelated address is ignored
    cfgWrite(8'hF6, 8'h18);
    #1;
    chk(p34Hs === 1'b0, "R2 unrelated address ignored", {7'b0, p34Hs}, 8'h00);
    runCycle(3'd2, 4'd6, 0, 0, 8'h00, "R2 mode kept after stray write");

    // ignored requests
    tryIgnoredReq(3'd0, "R3 idle code starts nothing");
    tryIgnoredReq(3'd7, "R3 code 7 starts nothing");
    tryIgnoredReq(3'd6, "R3 code 6 starts nothing");
    runCycle(3'd1, 4'd8, 3, 0, 8'h00, "R3 request while busy ignored");

    // mid-cycle config write: strobe held
    cfgWrite(8'hF8, 8'h00); benchStackExt = 1'b1;
    runCycle(3'd4, 4'd9, 0, 3, 8'h04, "R11 strobe held across config write");
    benchStackExt = 1'b0;
    runCycle(3'd4, 4'd6, 0, 0, 8'h00, "R11 R9 new stack setting at next cycle");

    // handshake mode
    cfgWrite(8'hF7, 8'h18); benchMode = 2'b11;
    #1;
    chk(p34Hs === 1'b1 && p34Out === 1'b1, "R10 handshake select", {6'b0, p34Out, p34Hs}, 8'h03);
    runCycle(3'd2, 4'd7, 0, 0, 8'h00, "R10 R7 data load in handshake mode");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule